// File: doc/BRIEF.md
# DMA Chain Tag Walker

The walker is the sequencing core of a source-chain DMA channel. Software writes a tag address and pulses start. The walker fetches a tag at that address and takes four fields from it: the tag type, a quadword count, an address and an interrupt flag. It then sets up the memory address and the next tag address according to the type, and moves the payload as a series of bursts on a data request port. After each packet it either fetches the next tag or ends the chain.

Each tag type has its own address rules. A tag can carry its payload right behind itself, or point at the payload elsewhere, or redirect the chain to a new tag address. For the type whose payload follows the tag, the tag address tracks the memory address after every burst. Software that polls the tag address therefore sees the transfer advance. Type codes that this channel does not handle raise an error and stop the walk.

Top module: `dmw_walker`

## Requirements
- R1: After reset, busy_o, done_o, irq_o, err_o, tag_req_o and dat_req_o are all 0.
- R2: A tag word holds the count in bits 15:0, the type in bits 30:28, the interrupt flag in bit 31 and the address in bits 63:32. The fetch of the first tag uses tadr_init_i, and each fetch is made at tadr_o while tag_req_o is high.
- R3: For the count type (code 1), the tag address steps by 16 and the memory address takes that new value. After every burst the tag address equals the memory address.
- R4: For the next type (code 2), the memory address becomes tag address + 16 and the tag address becomes the address field. The chain continues.
- R5: For the reference types (codes 3 and 4), the memory address becomes the address field and the tag address steps by 16. The chain continues.
- R6: For the reference-and-end type (code 0), the memory address becomes the address field and the tag address steps by 16. The chain ends after this packet.
- R7: For the end type (code 7), the memory address becomes tag address + 16 and the tag address is unchanged. The chain ends after this packet.
- R8: When tie_i is 1 and the tag's bit 31 is 1, the chain ends after the current packet and irq_o pulses together with done_o. When tie_i is 0, that bit has no effect.
- R9: A burst requests min(remaining count, BMAX) quadwords at madr_o. Each acknowledged burst adds length × 16 to the memory address and subtracts the length from the count. A tag with count 0 makes no burst.
- R10: The codes 5 and 6 set err_o, return the walker to idle without done_o, and leave tadr_o at the faulty tag's address. The next start clears err_o.
- R11: last_tag_o holds bits 31:16 of the last accepted tag, so its bits 14:12 give the type of the packet in flight.
- R12: done_o pulses for exactly one cycle, and only once the remaining count is 0 and the chain-end condition is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| tie_i | input | 1 | Enables the tag interrupt flag |
| tadr_init_i | input | AW | First tag address |
| tag_req_o | output | 1 | Tag fetch request at tadr_o |
| tag_ack_i | input | 1 | Tag response valid |
| tag_data_i | input | AW+32 | Tag word |
| dat_req_o | output | 1 | Burst request at madr_o |
| dat_len_o | output | 16 | Burst length in quadwords |
| dat_ack_i | input | 1 | Burst completed |
| tadr_o | output | AW | Current tag address |
| madr_o | output | AW | Current memory address |
| last_tag_o | output | 16 | Upper half of the low tag word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Chain finished (one cycle) |
| irq_o | output | 1 | Tag interrupt at finish |
| err_o | output | 1 | Unknown tag type seen |

## Verification
Five chains are run. The first is a count-type packet longer than one burst, followed by an end tag; it shows whether the tag address tracks the memory address across partial bursts and then stays fixed for the end type. The second is a mixed chain of next, reference, zero-count reference and reference-and-end tags; it separates the four address rules and shows that a zero-count tag is skipped. The same interrupt-flagged tag is walked with the enable set and with the enable cleared, which shows whether the flag forces an early end and pulses the interrupt. An unknown code then checks that the walker stops with an error and no completion, and that the next start clears it.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  localparam int QW_W = 16;
  localparam int HDR_W = 16;

  typedef enum logic [2:0] {
    TG_REFE = 3'd0,
    TG_CNT  = 3'd1,
    TG_NEXT = 3'd2,
    TG_REF  = 3'd3,
    TG_REFS = 3'd4,
    TG_CALL = 3'd5,
    TG_RET  = 3'd6,
    TG_END  = 3'd7
  } tag_id_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_MOVE  = 2'd2,
    S_FIN   = 2'd3
  } wstate_e;
endpackage

// File: rtl/dmw_tag_decode.sv
module dmw_tag_decode
  import dmw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW+31:0]    tag,
  input  logic [AW-1:0]     tadr,
  input  logic              tie,
  output logic [QW_W-1:0]   qwc,
  output logic [HDR_W-1:0]  hdr,
  output logic [AW-1:0]     madr_nx,
  output logic [AW-1:0]     tadr_nx,
  output logic              ends,
  output logic              irq_hit,
  output logic              bad
);
  logic [AW-1:0] step;
  logic [AW-1:0] field;
  tag_id_e       id;

  assign qwc     = tag[QW_W-1:0];
  assign hdr     = tag[31:16];
  assign field   = tag[32 +: AW];
  assign id      = tag_id_e'(tag[30:28]);
  assign irq_hit = tie & tag[31];
  assign step    = tadr + AW'(16);

  always_comb begin
    madr_nx = step;
    tadr_nx = step;
    ends    = 1'b0;
    bad     = 1'b0;
    case (id)
      TG_REFE: begin
        madr_nx = field;
        ends    = 1'b1;
      end
      TG_CNT: begin
        madr_nx = step;
      end
      TG_NEXT: begin
        tadr_nx = field;
      end
      TG_REF, TG_REFS: begin
        madr_nx = field;
      end
      TG_END: begin
        tadr_nx = tadr;
        ends    = 1'b1;
      end
      default: begin
        tadr_nx = tadr;
        bad     = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dmw_burst_size.sv
module dmw_burst_size
  import dmw_pkg::*;
#(
  parameter int BMAX = 4
) (
  input  logic [QW_W-1:0] left,
  output logic [QW_W-1:0] len
);
  localparam logic [QW_W-1:0] LIMIT = QW_W'(BMAX);

  assign len = (left > LIMIT) ? LIMIT : left;
endmodule

// File: rtl/dmw_walker.sv
module dmw_walker
  import dmw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int BMAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              tie_i,
  input  logic [AW-1:0]     tadr_init_i,
  output logic              tag_req_o,
  input  logic              tag_ack_i,
  input  logic [AW+31:0]    tag_data_i,
  output logic              dat_req_o,
  output logic [QW_W-1:0]   dat_len_o,
  input  logic              dat_ack_i,
  output logic [AW-1:0]     tadr_o,
  output logic [AW-1:0]     madr_o,
  output logic [HDR_W-1:0]  last_tag_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              err_o
);
  wstate_e          st_q, st_n;
  logic [AW-1:0]    tadr_q, tadr_n, madr_q, madr_n;
  logic [QW_W-1:0]  qwc_q, qwc_n;
  logic [HDR_W-1:0] hdr_q, hdr_n;
  logic             end_q, end_n, irq_q, irq_n, err_q, err_n;
  logic             upd_en;

  logic [QW_W-1:0]  d_qwc, blen, left_after;
  logic [HDR_W-1:0] d_hdr;
  logic [AW-1:0]    d_madr, d_tadr, madr_step;
  logic             d_ends, d_irq, d_bad, cnt_live;

  dmw_tag_decode #(.AW(AW)) u_dec (
    .tag     (tag_data_i),
    .tadr    (tadr_q),
    .tie     (tie_i),
    .qwc     (d_qwc),
    .hdr     (d_hdr),
    .madr_nx (d_madr),
    .tadr_nx (d_tadr),
    .ends    (d_ends),
    .irq_hit (d_irq),
    .bad     (d_bad)
  );

  dmw_burst_size #(.BMAX(BMAX)) u_bsz (
    .left (qwc_q),
    .len  (blen)
  );

  assign madr_step  = madr_q + (AW'(blen) << 4);
  assign left_after = qwc_q - blen;
  assign cnt_live   = (hdr_q[14:12] == TG_CNT);
  assign upd_en     = (st_q != S_IDLE) | start_i;

  always_comb begin
    st_n   = st_q;
    tadr_n = tadr_q;
    madr_n = madr_q;
    qwc_n  = qwc_q;
    hdr_n  = hdr_q;
    end_n  = end_q;
    irq_n  = irq_q;
    err_n  = err_q;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          tadr_n = tadr_init_i;
          err_n  = 1'b0;
          irq_n  = 1'b0;
          end_n  = 1'b0;
          st_n   = S_FETCH;
        end
      end
      S_FETCH: begin
        if (tag_ack_i) begin
          if (d_bad) begin
            err_n = 1'b1;
            st_n  = S_IDLE;
          end else begin
            tadr_n = d_tadr;
            madr_n = d_madr;
            qwc_n  = d_qwc;
            hdr_n  = d_hdr;
            end_n  = d_ends | d_irq;
            irq_n  = d_irq;
            if (d_qwc != '0)             st_n = S_MOVE;
            else if (d_ends | d_irq)     st_n = S_FIN;
            else                         st_n = S_FETCH;
          end
        end
      end
      S_MOVE: begin
        if (dat_ack_i) begin
          madr_n = madr_step;
          qwc_n  = left_after;
          if (cnt_live) tadr_n = madr_step;
          if (left_after == '0) st_n = end_q ? S_FIN : S_FETCH;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tadr_q <= '0;
      madr_q <= '0;
      qwc_q  <= '0;
      hdr_q  <= '0;
      end_q  <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      st_q   <= st_n;
      tadr_q <= tadr_n;
      madr_q <= madr_n;
      qwc_q  <= qwc_n;
      hdr_q  <= hdr_n;
      end_q  <= end_n;
      irq_q  <= irq_n;
      err_q  <= err_n;
    end
  end

  assign tag_req_o  = (st_q == S_FETCH);
  assign dat_req_o  = (st_q == S_MOVE);
  assign dat_len_o  = blen;
  assign tadr_o     = tadr_q;
  assign madr_o     = madr_q;
  assign last_tag_o = hdr_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_FIN);
  assign irq_o      = (st_q == S_FIN) & irq_q;
  assign err_o      = err_q;
endmodule

// File: rtl/dmw_walker_chk.sv
module dmw_walker_chk #(
  parameter int AW   = 32,
  parameter int BMAX = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tag_req_o,
  input logic           tag_ack_i,
  input logic [AW+31:0] tag_data_i,
  input logic           dat_req_o,
  input logic [15:0]    dat_len_o,
  input logic           dat_ack_i,
  input logic [AW-1:0]  tadr_o,
  input logic [AW-1:0]  madr_o,
  input logic [15:0]    last_tag_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           err_o
);
  p_one_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_req_o && dat_req_o));

  p_burst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_req_o |-> (dat_len_o != 16'd0 && dat_len_o <= 16'(BMAX)));

  p_cnt_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req_o && dat_ack_i && last_tag_o[14:12] == 3'd1) |=> (tadr_o == madr_o));

  p_end_keeps_tadr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_o && tag_ack_i && tag_data_i[30:28] == 3'd7) |=> $stable(tadr_o));

  p_ref_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_o && tag_ack_i && (tag_data_i[30:28] == 3'd3 || tag_data_i[30:28] == 3'd4))
    |=> (tadr_o == $past(tadr_o) + AW'(16) && madr_o == $past(tag_data_i[32 +: AW])));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !done_o));

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_o && !tag_ack_i) |=> (tag_req_o && $stable(tadr_o)));
endmodule

bind dmw_walker dmw_walker_chk #(.AW(AW), .BMAX(BMAX)) u_chk (.*);

// File: tb/dmw_walker_bench.sv
module dmw_walker_bench;
  localparam int AW = 32;

  logic clk, rst_n, start_i, tie_i, tag_ack_i, dat_ack_i;
  logic [AW-1:0]  tadr_init_i;
  logic [AW+31:0] tag_data_i;
  logic tag_req_o, dat_req_o, busy_o, done_o, irq_o, err_o;
  logic [15:0] dat_len_o, last_tag_o;
  logic [AW-1:0] tadr_o, madr_o;

  dmw_walker #(.AW(AW), .BMAX(4)) u_dmw_walker (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int kind;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
  } item_t;

  item_t sbq[$];
  string sbr[$];
  logic [63:0] tmem [64];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [63:0] mk(logic [2:0] id, logic irq, logic [15:0] q, logic [31:0] a);
    return {a, irq, id, 12'h000, q};
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(string rq, int kind, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    item_t it;
    it.kind = kind; it.a = a; it.b = b; it.c = c;
    sbq.push_back(it);
    sbr.push_back(rq);
  endtask

  task automatic pop(int kind, output item_t it, output string rq);
    if (sbq.size() == 0) begin
      checks++; errors++;
      $display("FAIL R12 unexpected event kind=%0d actual=%0d expected=none", kind, kind);
      it.kind = -1; rq = "none";
    end else begin
      it = sbq.pop_front();
      rq = sbr.pop_front();
      chk(rq, "event kind", 32'(it.kind), 32'(kind));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor and responder
  initial begin
    item_t it;
    string rq;
    tag_ack_i = 1'b0;
    dat_ack_i = 1'b0;
    tag_data_i = '0;
    forever begin
      @(negedge clk);
      tag_ack_i = 1'b0;
      dat_ack_i = 1'b0;
      if (rst_n) begin
        if (tag_req_o) begin
          pop(0, it, rq);
          if (it.kind == 0) chk(rq, "fetch address", tadr_o, it.a);
          tag_data_i = tmem[tadr_o[9:4]];
          tag_ack_i = 1'b1;
        end
        if (dat_req_o) begin
          pop(1, it, rq);
          if (it.kind == 1) begin
            chk(rq, "burst address", madr_o, it.a);
            chk(rq, "burst length", 32'(dat_len_o), it.b);
            chk(rq, "tag address during burst", tadr_o, it.c);
          end
          dat_ack_i = 1'b1;
        end
        if (done_o) begin
          pop(2, it, rq);
          if (it.kind == 2) begin
            chk(rq, "final tag address", tadr_o, it.a);
            chk(rq, "final memory address", madr_o, it.b);
            chk(rq, "interrupt", 32'(irq_o), it.c);
          end
        end
      end
    end
  end

  task automatic run_chain(logic [31:0] t0, logic tie);
    int n;
    @(negedge clk);
    tadr_init_i = t0;
    tie_i = tie;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk("R12", "scoreboard drained", 32'(sbq.size()), 32'd0);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) tmem[i] = '0;
    tmem[6'h00] = mk(3'd1, 1'b0, 16'd5, 32'h0);
    tmem[6'h06] = mk(3'd7, 1'b0, 16'd2, 32'h0);
    tmem[6'h10] = mk(3'd2, 1'b0, 16'd1, 32'h200);
    tmem[6'h20] = mk(3'd3, 1'b0, 16'd3, 32'h3000);
    tmem[6'h21] = mk(3'd4, 1'b0, 16'd0, 32'h4000);
    tmem[6'h22] = mk(3'd0, 1'b0, 16'd4, 32'h5000);
    tmem[6'h28] = mk(3'd1, 1'b1, 16'd1, 32'h0);
    tmem[6'h2a] = mk(3'd7, 1'b0, 16'd0, 32'h0);
    tmem[6'h30] = mk(3'd5, 1'b0, 16'd2, 32'h0);

    rst_n = 1'b0; start_i = 1'b0; tie_i = 1'b0; tadr_init_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy_o), 0);
    chk("R1", "done", 32'(done_o), 0);
    chk("R1", "irq", 32'(irq_o), 0);
    chk("R1", "err", 32'(err_o), 0);
    chk("R1", "tag_req", 32'(tag_req_o), 0);
    chk("R1", "dat_req", 32'(dat_req_o), 0);
    rst_n = 1'b1;

    // R2 R3 R7 R9: count tag of 5 split into 4+1, then end tag
    push("R2", 0, 32'h000, 0, 0);
    push("R3", 1, 32'h010, 4, 32'h010);
    push("R3", 1, 32'h050, 1, 32'h050);
    push("R3", 0, 32'h060, 0, 0);
    push("R7", 1, 32'h070, 2, 32'h060);
    push("R7", 2, 32'h060, 32'h090, 0);
    run_chain(32'h000, 1'b0);
    chk("R11", "last tag header after end", 32'(last_tag_o), 32'h7000);

    // R4 R5 R6 R9: next, ref, zero-count refs, refe
    push("R2", 0, 32'h100, 0, 0);
    push("R4", 1, 32'h110, 1, 32'h200);
    push("R4", 0, 32'h200, 0, 0);
    push("R5", 1, 32'h3000, 3, 32'h210);
    push("R5", 0, 32'h210, 0, 0);
    push("R9", 0, 32'h220, 0, 0);
    push("R6", 1, 32'h5000, 4, 32'h230);
    push("R6", 2, 32'h230, 32'h5040, 0);
    run_chain(32'h100, 1'b0);

    // R8: interrupt flag with enable forces end
    push("R8", 0, 32'h280, 0, 0);
    push("R3", 1, 32'h290, 1, 32'h290);
    push("R8", 2, 32'h2a0, 32'h2a0, 1);
    run_chain(32'h280, 1'b1);
    chk("R11", "last tag header with flag", 32'(last_tag_o), 32'h9000);

    // R8: same tag with enable cleared continues
    push("R8", 0, 32'h280, 0, 0);
    push("R8", 1, 32'h290, 1, 32'h290);
    push("R8", 0, 32'h2a0, 0, 0);
    push("R7", 2, 32'h2a0, 32'h2b0, 0);
    run_chain(32'h280, 1'b0);

    // R10: unknown code
    push("R10", 0, 32'h300, 0, 0);
    run_chain(32'h300, 1'b0);
    chk("R10", "err set", 32'(err_o), 1);
    chk("R10", "not busy", 32'(busy_o), 0);
    chk("R10", "tag address kept", tadr_o, 32'h300);

    // R10: next start clears the error
    push("R2", 0, 32'h2a0, 0, 0);
    push("R7", 2, 32'h2a0, 32'h2b0, 0);
    run_chain(32'h2a0, 1'b0);
    chk("R10", "err cleared", 32'(err_o), 0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule